// File: doc/BRIEF.md
# Static Memory Bus Controller

This block sits between an internal requester and an external bus of static devices: SRAM, ROM, NOR flash, or peripherals that follow SRAM-style signalling. It accepts one access at a time, given as a word address, write data, a byte mask and a read/write flag. It runs that access on the external bus through chip selects, address, output enable, per-lane write enables and data. It ends every access with a one-cycle done pulse. For reads, the captured data is presented on `rd_data` during that pulse.

The top bits of the address choose one of six banks. Each bank has its own timing register, which holds separate wait counts for reads and for writes and is loaded through a small configuration port. An access moves through setup, wait, strobe and finish phases. The wait phase lasts the bank's programmed count. It also stretches for as long as the active-low external wait input, after two-stage synchronization, is seen low. When both are in use, the later of the two ends the wait. An address whose bank field names no bank completes at once: no bus activity and zero read data.

Top module: `static_bus_ctrl`

## Requirements
- R1: After reset all chip selects, the output enable and every write-enable lane are high (inactive), `done` is low and `req_ready` is high.
- R2: The bank is the top three address bits. Values 0 to 5 drive only `mem_cs_n[value]` low for the access, and at no time is more than one chip select low.
- R3: Each bank keeps its own read and write wait counts, written with `cfg_we`. A bank that is never written keeps its reset counts of 15.
- R4: With the wait input high, a mapped access that is accepted on edge 0 shows `done` in the cycle after edge N+2. N is the bank's read count for reads and its write count for writes.
- R5: Chip select, address and write data stay constant from the first cycle of an access until its chip select rises again.
- R6: While the synchronized wait input is low, the wait phase is held. When the programmed count and the wait input are both in play, the access ends only after both are satisfied. A wait pulse must be held low for at least two clocks.
- R7: Read data is sampled from `mem_din` on the edge that ends the strobe phase, where the output enable is still low. It is shown on `rd_data` with `done`. The chip select is still low in the done cycle and goes high on the next edge.
- R8: During a write, only lanes whose `req_be` bit is 1 drive their `mem_we_n` bit low, and the output enable stays high.
- R9: An address with bank value 6 or 7 gives `done` in the cycle after the accepting edge, with `rd_data` zero and no chip select or write enable asserted.
- R10: `done` is high for exactly one cycle per access, and `req_ready` is high only when no access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for a bank timing register |
| cfg_bank | input | SEL_W (3) | Bank whose register is written |
| cfg_rd_wait | input | WAIT_W (4) | Read wait count to store |
| cfg_wr_wait | input | WAIT_W (4) | Write wait count to store |
| req_valid | input | 1 | Access request, taken when `req_ready` is high |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (16) | Word address; the top three bits select the bank |
| req_wdata | input | DATA_W (32) | Write data |
| req_be | input | BE_W (4) | Byte lanes to write |
| req_ready | output | 1 | Controller idle |
| done | output | 1 | One-cycle completion pulse |
| rd_data | output | DATA_W (32) | Read result, valid with `done` |
| mem_cs_n | output | NUM_CS (6) | Active-low chip selects |
| mem_addr | output | ADDR_W (16) | External address, zero when no bank is selected |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | BE_W (4) | Active-low per-lane write enables |
| mem_dout | output | DATA_W (32) | Write data toward the bus |
| mem_dout_en | output | 1 | Write data driver enable |
| mem_din | input | DATA_W (32) | Read data from the bus |
| mem_wait_n | input | 1 | Active-low external wait request |

## Verification
If the wait counter is loaded with the wrong field or bank, `done` moves off its predicted cycle in the very next access, so the latency check measures accept-to-done for every access. If the capture happens one phase late, it samples the bus after the output enable has risen, and the bench memory then returns a garbage pattern instead of stored data. Wrong lane masking or a wrong bank decode stays hidden until a later read of that location, so every write is followed by a read-back.

// File: rtl/static_bus_ctrl.sv
module static_bus_ctrl #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int NUM_CS = 6,
  parameter int WAIT_W = 4,
  localparam int SEL_W = $clog2(NUM_CS),
  localparam int BE_W  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [SEL_W-1:0]  cfg_bank,
  input  logic [WAIT_W-1:0] cfg_rd_wait,
  input  logic [WAIT_W-1:0] cfg_wr_wait,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [BE_W-1:0]   req_be,
  output logic              req_ready,
  output logic              done,
  output logic [DATA_W-1:0] rd_data,
  output logic [NUM_CS-1:0] mem_cs_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_oe_n,
  output logic [BE_W-1:0]   mem_we_n,
  output logic [DATA_W-1:0] mem_dout,
  output logic              mem_dout_en,
  input  logic [DATA_W-1:0] mem_din,
  input  logic              mem_wait_n
);

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_WAIT, S_STROBE, S_FINISH} state_t;

  state_t            state, nxt;
  logic [WAIT_W-1:0] rd_wait [NUM_CS];
  logic [WAIT_W-1:0] wr_wait [NUM_CS];
  logic [1:0]        sync_q;
  logic [SEL_W-1:0]  sel_q;
  logic              hit_q, wr_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic [BE_W-1:0]   be_q;
  logic [WAIT_W-1:0] cnt_q;

  wire [SEL_W-1:0]  req_sel = req_addr[ADDR_W-1 -: SEL_W];
  wire              req_hit = 32'(req_sel) < NUM_CS;
  wire [WAIT_W-1:0] req_n   = !req_hit ? '0 :
                              req_write ? wr_wait[req_sel] : rd_wait[req_sel];
  wire              stall   = ~sync_q[1];
  wire              accept  = req_valid && (state == S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CS; i++) begin
        rd_wait[i] <= '1;
        wr_wait[i] <= '1;
      end
    end else if (cfg_we && 32'(cfg_bank) < NUM_CS) begin
      rd_wait[cfg_bank] <= cfg_rd_wait;
      wr_wait[cfg_bank] <= cfg_wr_wait;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b11;
    else        sync_q <= {sync_q[0], mem_wait_n};
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:   if (req_valid) nxt = req_hit ? S_SETUP : S_FINISH;
      S_SETUP:  nxt = (cnt_q == '0 && !stall) ? S_STROBE : S_WAIT;
      S_WAIT:   if (cnt_q <= 1 && !stall) nxt = S_STROBE;
      S_STROBE: nxt = S_FINISH;
      default:  nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      sel_q   <= '0;
      hit_q   <= 1'b0;
      wr_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      be_q    <= '0;
      cnt_q   <= '0;
      rdata_q <= '0;
    end else begin
      state <= nxt;
      if (accept) begin
        sel_q   <= req_sel;
        hit_q   <= req_hit;
        wr_q    <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        cnt_q   <= req_n;
        rdata_q <= '0;
      end
      if (state == S_WAIT && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      if (state == S_STROBE && !wr_q) rdata_q <= mem_din;
    end
  end

  wire on_bus    = hit_q && (state != S_IDLE);
  wire strobe_ph = hit_q && (state == S_WAIT || state == S_STROBE);

  assign req_ready   = (state == S_IDLE);
  assign done        = (state == S_FINISH);
  assign rd_data     = rdata_q;
  assign mem_cs_n    = on_bus ? ~(NUM_CS'(1) << sel_q) : '1;
  assign mem_addr    = on_bus ? addr_q : '0;
  assign mem_oe_n    = !(strobe_ph && !wr_q);
  assign mem_we_n    = (strobe_ph && wr_q) ? ~be_q : '1;
  assign mem_dout    = wdata_q;
  assign mem_dout_en = on_bus && wr_q;

  // R2
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~mem_cs_n) <= 1);

  // R5
  bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n != '1 && $past(mem_cs_n != '1)) |-> ($stable(mem_cs_n) && $stable(mem_addr) && $stable(mem_dout)));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && stall) |=> (state == S_WAIT));

  // R7
  cs_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_cs_n == '1 && $past(mem_cs_n != '1)) |-> $past(done));

  // R8
  we_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we_n != '1) |-> (mem_cs_n != '1 && mem_oe_n));

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

// File: tb/test_static_bus_ctrl.sv
`timescale 1ns/1ps
module test_static_bus_ctrl;

  logic        clk = 0, rst_n = 0;
  logic        cfg_we = 0;
  logic [2:0]  cfg_bank = 0;
  logic [3:0]  cfg_rd_wait = 0, cfg_wr_wait = 0;
  logic        req_valid = 0, req_write = 0;
  logic [15:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic [3:0]  req_be = 0;
  logic        req_ready, done;
  logic [31:0] rd_data;
  logic [5:0]  mem_cs_n;
  logic [15:0] mem_addr;
  logic        mem_oe_n;
  logic [3:0]  mem_we_n;
  logic [31:0] mem_dout, mem_din;
  logic        mem_dout_en;
  logic        mem_wait_n = 1;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  static_bus_ctrl i_static_bus_ctrl (
    .clk, .rst_n, .cfg_we, .cfg_bank, .cfg_rd_wait, .cfg_wr_wait,
    .req_valid, .req_write, .req_addr, .req_wdata, .req_be,
    .req_ready, .done, .rd_data,
    .mem_cs_n, .mem_addr, .mem_oe_n, .mem_we_n, .mem_dout, .mem_dout_en,
    .mem_din, .mem_wait_n
  );

  logic [31:0] bus_mem [6][16];
  logic [31:0] shadow  [6][16];

  always @(posedge clk)
    for (int b = 0; b < 6; b++)
      if (!mem_cs_n[b])
        for (int l = 0; l < 4; l++)
          if (!mem_we_n[l]) bus_mem[b][mem_addr[3:0]][8*l +: 8] <= mem_dout[8*l +: 8];

  always_comb begin
    mem_din = 32'hDEAD_BEEF;
    if (!mem_oe_n)
      for (int b = 0; b < 6; b++)
        if (!mem_cs_n[b]) mem_din = bus_mem[b][mem_addr[3:0]];
  end

  typedef struct {
    bit          hit;
    int          bank;
    int          lat;
    logic [31:0] data;
    logic [15:0] addr;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int b, input int rd, input int wr);
    @(negedge clk);
    cfg_we = 1; cfg_bank = 3'(b); cfg_rd_wait = 4'(rd); cfg_wr_wait = 4'(wr);
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic access(input bit wr, input logic [15:0] a, input logic [31:0] wd,
                        input logic [3:0] be, input int n, input int wk, input string tag);
    exp_t e;
    int b = int'(a[15:13]);
    e.hit  = b < 6;
    e.bank = b;
    e.addr = a;
    e.tag  = tag;
    e.data = 0;
    if (!e.hit) e.lat = 1;
    else if (wk > 0 && wk + 4 > n + 3) e.lat = wk + 4;
    else e.lat = n + 3;
    if (e.hit) begin
      if (wr) begin
        for (int l = 0; l < 4; l++)
          if (be[l]) shadow[b][a[3:0]][8*l +: 8] = wd[8*l +: 8];
      end else e.data = shadow[b][a[3:0]];
    end
    q.push_back(e);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = wd; req_be = be;
    if (wk > 0) mem_wait_n = 0;
    @(negedge clk);
    req_valid = 0;
    if (wk > 0) begin
      repeat (wk - 1) @(negedge clk);
      mem_wait_n = 1;
    end
    while (!done) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // scoreboard monitor
  initial begin
    bit busy = 0, release_chk = 0;
    int cnt = 0;
    exp_t e;
    forever begin
      @(negedge clk); #1;
      if (release_chk) begin
        // R7 chip select released on the edge after the done cycle; R10 single pulse
        chk(mem_cs_n == 6'h3F, "R7", "cs after done", 32'(mem_cs_n), 32'h3F);
        chk(!done, "R10", "done width", 32'(done), 0);
        release_chk = 0;
      end
      if (busy) begin
        cnt++;
        chk(!req_ready, "R10", "ready while busy", 32'(req_ready), 0);
        if (done) begin
          busy = 0;
          if (q.size() == 0) chk(0, "R10", "unexpected done", 1, 0);
          else begin
            e = q.pop_front();
            chk(cnt == e.lat, e.tag, "latency", 32'(cnt), 32'(e.lat));
            chk(rd_data == e.data, e.hit ? "R7" : "R9", "rd_data", rd_data, e.data);
            if (e.hit) begin
              chk(mem_cs_n == ~(6'b1 << e.bank), "R2", "chip select", 32'(mem_cs_n), 32'(~(6'b1 << e.bank)));
              chk(mem_addr == e.addr, "R5", "address held", 32'(mem_addr), 32'(e.addr));
            end else
              chk(mem_cs_n == 6'h3F && mem_we_n == 4'hF, "R9", "no bus activity",
                  {22'b0, mem_cs_n, mem_we_n}, {22'b0, 6'h3F, 4'hF});
            release_chk = 1;
          end
        end
      end else begin
        if (done) chk(0, "R10", "done without access", 1, 0);
        if (req_valid && req_ready) begin busy = 1; cnt = 0; end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int b = 0; b < 6; b++)
      for (int i = 0; i < 16; i++) begin
        bus_mem[b][i] = 32'hA000_0000 | (b << 16) | (i * 32'h0101);
        shadow[b][i]  = bus_mem[b][i];
      end
    repeat (5) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(mem_cs_n == 6'h3F, "R1", "cs reset", 32'(mem_cs_n), 32'h3F);
    chk(mem_oe_n && mem_we_n == 4'hF, "R1", "oe/we reset", {27'b0, mem_oe_n, mem_we_n}, 32'h1F);
    chk(!done && req_ready, "R1", "done/ready reset", {30'b0, done, req_ready}, 32'h1);

    // R3 per-bank counts; bank 5 keeps reset counts
    set_cfg(0, 2, 1);
    set_cfg(1, 0, 3);
    set_cfg(2, 1, 1);
    set_cfg(3, 8, 0);
    set_cfg(4, 3, 2);

    // R4 writes with each bank's write count
    access(1, 16'h0003, 32'h1122_3344, 4'hF, 1, 0, "R4");
    access(1, 16'h2005, 32'h5566_7788, 4'hF, 3, 0, "R4");
    access(1, 16'h8007, 32'hCAFE_F00D, 4'hF, 2, 0, "R4");
    access(1, 16'hA002, 32'h0BAD_CAFE, 4'hF, 15, 0, "R3");
    // reads with read counts
    access(0, 16'h0003, 0, 4'h0, 2, 0, "R4");
    access(0, 16'h2005, 0, 4'h0, 0, 0, "R4");
    access(0, 16'h8007, 0, 4'h0, 3, 0, "R4");
    access(0, 16'hA002, 0, 4'h0, 15, 0, "R3");
    access(0, 16'h6009, 0, 4'h0, 8, 0, "R4");
    // R8 partial lane writes, then read back
    access(1, 16'h2005, 32'hFFEE_DDCC, 4'b1010, 3, 0, "R8");
    access(0, 16'h2005, 0, 4'h0, 0, 0, "R8");
    access(1, 16'h0004, 32'h1234_5678, 4'b0001, 1, 0, "R8");
    access(0, 16'h0004, 0, 4'h0, 2, 0, "R8");
    // R6 wait pin dominates, then count dominates
    access(1, 16'h4001, 32'h7777_8888, 4'hF, 1, 6, "R6");
    access(0, 16'h4001, 0, 4'h0, 1, 6, "R6");
    access(0, 16'h600A, 0, 4'h0, 8, 3, "R6");
    access(0, 16'h4002, 0, 4'h0, 1, 2, "R6");
    // R9 unmapped banks 6 and 7
    access(0, 16'hC000, 0, 4'h0, 0, 0, "R9");
    access(1, 16'hE001, 32'hFFFF_FFFF, 4'hF, 0, 0, "R9");
    access(0, 16'h0003, 0, 4'h0, 2, 0, "R9");

    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R10", "pending items", 32'(q.size()), 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule